// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It receives one decoded scalar register-to-register operation and runs it as a hardware for-loop over a vector length chosen at run time. The decoded operation carries a destination and two source register numbers, a vector flag for each of them, the vector length and a destination predicate mask. The sequencer walks the element indices in ascending order. It tests each element's predicate bit. For every enabled element it raises an issue request, with each vector-flagged register number stepped by the element index.

While the loop runs, the block holds the program counter. A one-cycle completion pulse ends the loop, and the fetch stage may then move on. The loop issues at most one element per cycle. A disabled element costs one cycle and issues nothing. An enabled element waits on a valid/ready handshake with the issue stage.

Top module: `vec_elem_seq`

## Requirements
- R1: Elements are handled strictly in ascending index order 0 .. VL-1. Each issue request reports its element index on `iss_idx`.
- R2: `pc_hold` is low while idle. It is high from the cycle after an operation is accepted up to and including the cycle of `seq_done`. `op_start` has no effect while `pc_hold` is high.
- R3: For an operand whose flag is set, the register number issued for element i is (base + i) mod 128. The flag bits in `op_vec` are: bit 0 destination, bit 1 first source, bit 2 second source.
- R4: For an operand whose flag is clear, the issued register number equals its base for every element.
- R5: When bit i of `op_pred` is clear, element i raises no issue request. Skipping it takes exactly one cycle.
- R6: An issue request stays valid with stable index and register numbers until `iss_ready` is high. The loop advances past an enabled element only on an accepted transfer.
- R7: With VL = 0 the block raises no issue request, and `seq_done` and `pc_hold` are high for exactly the one cycle after acceptance.
- R8: `seq_done` is a single-cycle pulse in the cycle after the last element was accepted or skipped. `pc_hold` is low in the following cycle.
- R9: A requested VL above MAX_VL (8 by default) is treated as MAX_VL.
- R10: After reset, `pc_hold`, `iss_valid` and `seq_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Decoded operation present; accepted when idle |
| op_rt | input | REG_W | Destination base register |
| op_ra | input | REG_W | First source base register |
| op_rb | input | REG_W | Second source base register |
| op_vec | input | 3 | Vector flags: bit 0 dest, bit 1 src A, bit 2 src B |
| op_vl | input | VL_IN_W | Requested vector length |
| op_pred | input | MAX_VL | Destination predicate mask, bit i enables element i |
| pc_hold | output | 1 | Program counter must not advance |
| iss_valid | output | 1 | Element issue request |
| iss_ready | input | 1 | Issue stage accepts the request |
| iss_rt | output | REG_W | Element destination register |
| iss_ra | output | REG_W | Element first source register |
| iss_rb | output | REG_W | Element second source register |
| iss_idx | output | IDX_W | Element index |
| seq_done | output | 1 | Loop complete pulse |

## Verification
The bench sweeps every VL from 0 to one past the maximum, against masks that are full, empty, alternating and irregular, all eight flag combinations, and bases close to the 127/0 wrap. An adder that does not wrap, or that steps a scalar operand, would issue wrong register numbers. A design that does not clamp VL would issue extra elements. Back-pressure patterns expose a loop that advances on valid instead of on the transfer, and a skip that costs an extra cycle or lets a masked element through. VL = 0 catches a loop that issues element 0 anyway. A stray `op_start` during a run catches an operation that gets latched a second time.

// File: rtl/vls_pkg.sv
package vls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } vls_state_e;

   localparam int unsigned N_OPND = 3;
   localparam int unsigned OPND_RT = 0;
   localparam int unsigned OPND_RA = 1;
   localparam int unsigned OPND_RB = 2;
endpackage

// File: rtl/vls_offset_ctr.sv
module vls_offset_ctr #(
   parameter int unsigned REG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             is_vec,
   input  logic [REG_W-1:0] base,
   output logic [REG_W-1:0] reg_num
);
   logic [REG_W-1:0] off_q;

   if (REG_W < 1) begin : g_bad_w
      $error("vls_offset_ctr: REG_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              off_q <= '0;
      else if (clr)            off_q <= '0;
      else if (step && is_vec) off_q <= off_q + REG_W'(1);
   end

   // modular add: truncation to REG_W bits gives the wrap
   assign reg_num = base + off_q;

   p_scalar_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !is_vec |-> off_q == '0);
   p_vec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_vec && !clr) |=> off_q == $past(off_q) + REG_W'(1));
endmodule

// File: rtl/vls_pred_gate.sv
module vls_pred_gate (
   input  logic run,
   input  logic pred_bit,
   input  logic iss_ready,
   output logic iss_valid,
   output logic step
);
   always_comb begin
      iss_valid = run & pred_bit;
      step      = run & (~pred_bit | iss_ready);
   end
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
   import vls_pkg::*;
#(
   parameter int unsigned MAX_VL  = 8,
   parameter int unsigned VL_IN_W = 5,
   localparam int unsigned VL_W   = $clog2(MAX_VL + 1),
   localparam int unsigned IDX_W  = $clog2(MAX_VL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VL_IN_W-1:0] vl_in,
   input  logic [MAX_VL-1:0]  pred_in,
   input  logic               step,
   output logic               accept,
   output vls_state_e         state,
   output logic [IDX_W-1:0]   idx,
   output logic               pred_bit
);
   vls_state_e        state_q, state_d;
   logic [VL_W-1:0]   vl_q, vl_eff;
   logic [MAX_VL-1:0] pred_q;
   logic [IDX_W-1:0]  idx_q;
   logic              last;

   if (MAX_VL < 2) begin : g_bad_vl
      $error("vls_ctrl: MAX_VL must be at least 2");
   end
   if (VL_IN_W < VL_W) begin : g_bad_vlin
      $error("vls_ctrl: VL_IN_W too narrow for MAX_VL");
   end

   always_comb begin
      if (vl_in > VL_IN_W'(MAX_VL)) vl_eff = VL_W'(MAX_VL);
      else                          vl_eff = VL_W'(vl_in);
   end

   assign accept = start && (state_q == ST_IDLE);
   assign last   = (VL_W'(idx_q) + VL_W'(1)) == vl_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept) state_d = (vl_eff == '0) ? ST_FIN : ST_RUN;
         ST_RUN:  if (step && last) state_d = ST_FIN;
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vl_q    <= '0;
         pred_q  <= '0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            vl_q   <= vl_eff;
            pred_q <= pred_in;
            idx_q  <= '0;
         end else if (state_q == ST_RUN && step && !last) begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   assign state    = state_q;
   assign idx      = idx_q;
   assign pred_bit = pred_q[idx_q];

   p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !step) |=> (state_q == ST_RUN) && $stable(idx_q));
   p_idx_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && step && !last) |=> idx_q == $past(idx_q) + IDX_W'(1));
   p_vl_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RUN |-> vl_q <= VL_W'(MAX_VL));
   p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(vl_q) && $stable(pred_q));
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vls_pkg::*;
#(
   parameter int unsigned REG_W   = 7,
   parameter int unsigned MAX_VL  = 8,
   parameter int unsigned VL_IN_W = 5,
   localparam int unsigned IDX_W  = $clog2(MAX_VL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_start,
   input  logic [REG_W-1:0]   op_rt,
   input  logic [REG_W-1:0]   op_ra,
   input  logic [REG_W-1:0]   op_rb,
   input  logic [2:0]         op_vec,
   input  logic [VL_IN_W-1:0] op_vl,
   input  logic [MAX_VL-1:0]  op_pred,
   output logic               pc_hold,
   output logic               iss_valid,
   input  logic               iss_ready,
   output logic [REG_W-1:0]   iss_rt,
   output logic [REG_W-1:0]   iss_ra,
   output logic [REG_W-1:0]   iss_rb,
   output logic [IDX_W-1:0]   iss_idx,
   output logic               seq_done
);
   vls_state_e       state;
   logic             accept, step, pred_bit, run;
   logic [IDX_W-1:0] idx;
   logic [REG_W-1:0] base_q [N_OPND];
   logic [REG_W-1:0] base_in [N_OPND];
   logic [REG_W-1:0] reg_out [N_OPND];
   logic [N_OPND-1:0] vec_q;

   assign base_in[OPND_RT] = op_rt;
   assign base_in[OPND_RA] = op_ra;
   assign base_in[OPND_RB] = op_rb;

   vls_ctrl #(.MAX_VL(MAX_VL), .VL_IN_W(VL_IN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(op_start), .vl_in(op_vl),
      .pred_in(op_pred), .step(step), .accept(accept), .state(state),
      .idx(idx), .pred_bit(pred_bit)
   );

   assign run = (state == ST_RUN);

   vls_pred_gate u_gate (
      .run(run), .pred_bit(pred_bit), .iss_ready(iss_ready),
      .iss_valid(iss_valid), .step(step)
   );

   for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
            vec_q[g]  <= 1'b0;
         end else if (accept) begin
            base_q[g] <= base_in[g];
            vec_q[g]  <= op_vec[g];
         end
      end

      vls_offset_ctr #(.REG_W(REG_W)) u_off (
         .clk(clk), .rst_n(rst_n), .clr(accept), .step(step),
         .is_vec(vec_q[g]), .base(base_q[g]), .reg_num(reg_out[g])
      );
   end

   assign iss_rt   = reg_out[OPND_RT];
   assign iss_ra   = reg_out[OPND_RA];
   assign iss_rb   = reg_out[OPND_RB];
   assign iss_idx  = idx;
   assign pc_hold  = (state != ST_IDLE);
   assign seq_done = (state == ST_FIN);

   p_issue_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> pc_hold);
   p_stall_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=> iss_valid && $stable(iss_idx) &&
         $stable(iss_rt) && $stable(iss_ra) && $stable(iss_rb));
   p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !pred_bit) |=> !(iss_valid && iss_idx == $past(idx)));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done && !pc_hold);
   p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_vl == '0) |=> seq_done && !iss_valid);
endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 7;
   localparam int MAX_VL = 8;
   localparam int VL_IN_W = 5;
   localparam int IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_start = 1'b0;
   logic [REG_W-1:0] op_rt = '0, op_ra = '0, op_rb = '0;
   logic [2:0] op_vec = '0;
   logic [VL_IN_W-1:0] op_vl = '0;
   logic [MAX_VL-1:0] op_pred = '0;
   logic iss_ready = 1'b0;
   logic pc_hold, iss_valid, seq_done;
   logic [REG_W-1:0] iss_rt, iss_ra, iss_rb;
   logic [IDX_W-1:0] iss_idx;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_elem_seq #(.REG_W(REG_W), .MAX_VL(MAX_VL), .VL_IN_W(VL_IN_W)) dut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_rt(op_rt),
      .op_ra(op_ra), .op_rb(op_rb), .op_vec(op_vec), .op_vl(op_vl),
      .op_pred(op_pred), .pc_hold(pc_hold), .iss_valid(iss_valid),
      .iss_ready(iss_ready), .iss_rt(iss_rt), .iss_ra(iss_ra),
      .iss_rb(iss_rb), .iss_idx(iss_idx), .seq_done(seq_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic logic [REG_W-1:0] exp_reg(input logic [REG_W-1:0] b,
                                                 input bit v, input int e);
      return v ? REG_W'(int'(b) + e) : b;
   endfunction

   // next enabled element at or after p, or -1
   function automatic int next_on(input logic [MAX_VL-1:0] m, input int p, input int n);
      for (int k = p; k < n; k++) if (m[k]) return k;
      return -1;
   endfunction

   task automatic run_case(input logic [REG_W-1:0] rt, ra, rb, input logic [2:0] vf,
                           input int vl, input logic [MAX_VL-1:0] pm,
                           input int rmode, input bit poke);
      int n, ptr, e, cyc, stalls, run_cyc;
      bit rdy, got_done;
      string tag;
      n = (vl > MAX_VL) ? MAX_VL : vl;
      tag = (vl > MAX_VL) ? "R9" : "R1";
      @(negedge clk);
      chk(pc_hold == 1'b0, "R2 idle hold", int'(pc_hold), 0);
      op_rt = rt; op_ra = ra; op_rb = rb; op_vec = vf;
      op_vl = VL_IN_W'(vl); op_pred = pm; op_start = 1'b1;
      ptr = 0; cyc = 0; stalls = 0; run_cyc = 0; got_done = 0;
      for (int it = 0; it < 100; it++) begin
         @(negedge clk);
         op_start = 1'b0;
         if (seq_done) begin
            got_done = 1;
            chk(next_on(pm, ptr, n) == -1, {tag, " done before all elements"}, ptr, n);
            chk(run_cyc == n + stalls, "R5 skip/step cycle count", run_cyc, n + stalls);
            if (vl == 0) chk(cyc == 0 && pc_hold, "R7 zero length done", cyc, 0);
            break;
         end
         chk(pc_hold == 1'b1, "R2 hold while running", int'(pc_hold), 1);
         run_cyc++;
         rdy = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 1) : ((cyc % 2) == 1);
         iss_ready = rdy;
         if (iss_valid) begin
            e = next_on(pm, ptr, n);
            if (e < 0) begin
               chk(0, "R5 unexpected issue", int'(iss_idx), -1);
            end else begin
               chk(int'(iss_idx) == e, {tag, " element order"}, int'(iss_idx), e);
               chk(iss_rt == exp_reg(rt, vf[0], e), vf[0] ? "R3 dest reg" : "R4 dest reg",
                   int'(iss_rt), int'(exp_reg(rt, vf[0], e)));
               chk(iss_ra == exp_reg(ra, vf[1], e), vf[1] ? "R3 srcA reg" : "R4 srcA reg",
                   int'(iss_ra), int'(exp_reg(ra, vf[1], e)));
               chk(iss_rb == exp_reg(rb, vf[2], e), vf[2] ? "R3 srcB reg" : "R4 srcB reg",
                   int'(iss_rb), int'(exp_reg(rb, vf[2], e)));
               if (rdy) ptr = e + 1;
               else stalls++;
            end
         end
         if (poke && cyc == 1) begin
            op_start = 1'b1; op_rt = ~rt; op_vl = VL_IN_W'(3); op_pred = ~pm; op_vec = ~vf;
         end
         cyc++;
      end
      iss_ready = 1'b0;
      chk(got_done, "R8 done seen", int'(got_done), 1);
      @(negedge clk);
      chk(!seq_done && !pc_hold, "R8 single pulse", int'(seq_done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [MAX_VL-1:0] masks [5];
      logic [REG_W-1:0] bases [3];
      masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'hA5;
      masks[3] = 8'h5A; masks[4] = 8'h81;
      bases[0] = 7'd126; bases[1] = 7'd0; bases[2] = 7'd121;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!pc_hold && !iss_valid && !seq_done, "R10 reset outputs",
          int'({pc_hold, iss_valid, seq_done}), 0);
      rst_n = 1'b1;
      for (int vl = 0; vl <= MAX_VL + 1; vl++)
         for (int m = 0; m < 5; m++)
            for (int f = 0; f < 8; f++)
               run_case(bases[(vl + f) % 3], bases[(vl + f + 1) % 3],
                        REG_W'(127 - vl), 3'(f), vl, masks[m],
                        (vl + m + f) % 3, ((f + m) % 4) == 0);
      // R7 zero length with back-pressure
      run_case(7'd5, 7'd6, 7'd7, 3'b111, 0, 8'hFF, 2, 1'b0);
      // R9 large requested length
      run_case(7'd120, 7'd127, 7'd3, 3'b101, 31, 8'hFF, 1, 1'b1);
      summary();
   end
endmodule